// File: doc/BRIEF.md
# Supply-Pulse Configuration Decoder

This block turns timed pulse events on a supply rail into configuration commands. A level detector outside the block digitizes five kinds of event: start, stop, small modulation pulse, pre-store and store. The block times the gap between successive small pulses with a 32768 Hz tick. It decodes each gap as one of three commands: step the instruction state, shift in a 0, or shift in a 1.

The instruction state selects what the block does. State 1 reports the oscillator rate divided by 1024. State 2 reports the inhibit-time waveform. States 3, 4 and 5 address configuration words A, B and C. In those three states, a pre-store followed by a store ORs the 8-bit shift register into the addressed word, because the cells can only be set. The same shift register also acts as a one-hot read-back pointer that drives a load-current output.

The three words are copied to `cfg_o` once after reset and held there for the timing and motor blocks. The cells themselves are cleared only by the blank input, which models a part as delivered.

Top module: `cfg_pulse_decoder`

## Requirements
- R1: After `rst_ni` is released, `state_o` is 0 and `load_o` is 0. `cfg_o` holds the word contents, with word A in bits [7:0], word B in [15:8] and word C in [23:16].
- R2: A start event sets `state_o` to 1 and clears the shift register. A later read-back in states 3 to 5, before any bit has been shifted in, therefore drives `load_o` low.
- R3: After start, small pulses that arrive before 655 ticks have been counted are ignored. The first small pulse at or after that point only sets the timing reference and changes no state.
- R4: A gap of 20 to 26 ticks between small pulses steps `state_o` by one, and the state saturates at 5.
- R5: A gap of 53 to 58 ticks shifts in a 0 and a gap of 86 to 91 ticks shifts in a 1. Each new bit enters at bit 7 while the register moves toward bit 0, so the first bit sent ends in bit 0.
- R6: A gap outside all three windows is ignored. The gap timer restarts at every small pulse after the reference, including ignored ones.
- R7: In states 3, 4 and 5, a pre-store followed by a store ORs the shift register into word A, B or C. Bits never return to 0, and `state_o` becomes 0.
- R8: A store that has no preceding pre-store writes nothing and leaves the state unchanged.
- R9: A stop event returns `state_o` to 0. A session with no small pulse for 65536 ticks also returns to 0.
- R10: In states 3 to 5, `load_o` is 1 exactly when the shift register and the addressed word share a set bit. In state 0, `load_o` is 0.
- R11: In state 1, `load_o` is a square wave with a period of 1024 ticks, high for 512 of them.
- R12: In state 2, `load_o` has a period of 1024 + 4·n ticks and is high for the first 512 ticks, where n is `cfg_o[7:1]`.
- R13: `cfg_o` is sampled once after reset. Stores made later do not change it until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset of control and snapshot |
| otp_blank_ni | input | 1 | Active-low clear of the settable word cells |
| tick_i | input | 1 | 32768 Hz timing enable |
| start_i | input | 1 | Start pulse event |
| stop_i | input | 1 | Stop pulse event |
| mod_i | input | 1 | Small modulation pulse event |
| prestore_i | input | 1 | Pre-store pulse event |
| store_i | input | 1 | Store pulse event |
| state_o | output | 3 | Instruction state, 0 when idle |
| load_o | output | 1 | Read-back load enable and measurement output |
| cfg_o | output | 24 | Configuration words held since reset |

## Verification
Gap lengths are driven just inside and just outside each window (19, 20, 26, 27 and others), so an off-by-one window edge shows up as a wrong state step. A short ignored gap followed by a gap that would only qualify when added to it separates a timer that restarts from one that keeps running. Read-back walks the one-hot pointer across every bit of words written with asymmetric patterns, which exposes reversed shift direction and lost set-only merges. The two measurement states are checked by counting high samples and the spacing between rising edges.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef enum logic [1:0] {
    IV_NONE,
    IV_INC,
    IV_ZERO,
    IV_ONE
  } iv_kind_e;
endpackage

// File: rtl/cfg_interval_timer.sv
module cfg_interval_timer
  import cfg_pkg::*;
#(
  parameter int unsigned TIMEOUT_T = 65536,
  parameter int unsigned WAIT_T    = 655,
  parameter int unsigned INC_LO    = 20,
  parameter int unsigned INC_HI    = 26,
  parameter int unsigned ZERO_LO   = 53,
  parameter int unsigned ZERO_HI   = 58,
  parameter int unsigned ONE_LO    = 86,
  parameter int unsigned ONE_HI    = 91
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     restart_i,
  input  logic     pulse_i,
  output iv_kind_e kind_o,
  output logic     timeout_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_T + 1);

  logic [CW-1:0] cnt_q;
  logic          ref_q;
  logic          accept;

  assign accept    = pulse_i && (ref_q || cnt_q >= CW'(WAIT_T));
  assign timeout_o = (cnt_q == CW'(TIMEOUT_T));

  always_comb begin
    kind_o = IV_NONE;
    if (pulse_i && ref_q) begin
      if (cnt_q >= CW'(INC_LO) && cnt_q <= CW'(INC_HI))        kind_o = IV_INC;
      else if (cnt_q >= CW'(ZERO_LO) && cnt_q <= CW'(ZERO_HI)) kind_o = IV_ZERO;
      else if (cnt_q >= CW'(ONE_LO) && cnt_q <= CW'(ONE_HI))   kind_o = IV_ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ref_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '0;
      ref_q <= 1'b0;
    end else if (accept) begin
      cnt_q <= '0;
      ref_q <= 1'b1;
    end else if (tick_i && !timeout_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_otp_bank.sv
module cfg_otp_bank #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 3
) (
  input  logic                       clk_i,
  input  logic                       blank_ni,
  input  logic                       wr_en_i,
  input  logic [$clog2(N)-1:0]       wr_sel_i,
  input  logic [W-1:0]               wr_data_i,
  output logic [N-1:0][W-1:0]        words_o
);
  localparam int unsigned SELW = $clog2(N);

  for (genvar g = 0; g < N; g++) begin : g_word
    logic [W-1:0] cell_q;
    always_ff @(posedge clk_i or negedge blank_ni) begin
      if (!blank_ni) cell_q <= '0;
      else if (wr_en_i && wr_sel_i == SELW'(g)) cell_q <= cell_q | wr_data_i;
    end
    assign words_o[g] = cell_q;
  end
endmodule

// File: rtl/cfg_meas_gen.sv
module cfg_meas_gen #(
  parameter int unsigned DIV_LOG2 = 10,
  parameter int unsigned BASE_T   = 1024,
  parameter int unsigned STEP_T   = 4,
  parameter int unsigned HIGH_T   = 512,
  parameter int unsigned NW       = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [NW-1:0] step_cnt_i,
  output logic          div_o,
  output logic          inh_o
);
  localparam int unsigned PW = $clog2(BASE_T + STEP_T * ((1 << NW) - 1) + 1);

  logic [DIV_LOG2-1:0] div_q;
  logic [PW-1:0]       ph_q;
  logic [PW-1:0]       period;

  assign period = PW'(BASE_T) + PW'(STEP_T) * PW'(step_cnt_i);
  assign div_o  = div_q[DIV_LOG2-1];
  assign inh_o  = ph_q < PW'(HIGH_T);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      ph_q  <= '0;
    end else if (tick_i) begin
      div_q <= div_q + 1'b1;
      ph_q  <= (ph_q >= period - 1'b1) ? '0 : ph_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_pulse_decoder.sv
module cfg_pulse_decoder
  import cfg_pkg::*;
#(
  parameter int unsigned W         = 8,
  parameter int unsigned NUM_WORDS = 3,
  parameter int unsigned TIMEOUT_T = 65536,
  parameter int unsigned WAIT_T    = 655,
  parameter int unsigned INC_LO    = 20,
  parameter int unsigned INC_HI    = 26,
  parameter int unsigned ZERO_LO   = 53,
  parameter int unsigned ZERO_HI   = 58,
  parameter int unsigned ONE_LO    = 86,
  parameter int unsigned ONE_HI    = 91
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             otp_blank_ni,
  input  logic                             tick_i,
  input  logic                             start_i,
  input  logic                             stop_i,
  input  logic                             mod_i,
  input  logic                             prestore_i,
  input  logic                             store_i,
  output logic [$clog2(NUM_WORDS+3)-1:0]   state_o,
  output logic                             load_o,
  output logic [NUM_WORDS*W-1:0]           cfg_o
);
  localparam int unsigned SW      = $clog2(NUM_WORDS + 3);
  localparam int unsigned SELW    = $clog2(NUM_WORDS);
  localparam int unsigned LAST_ST = NUM_WORDS + 2;
  localparam int unsigned FIRST_W = 3;

  logic [SW-1:0]                state_q;
  logic [W-1:0]                 sr_q;
  logic                         arm_q;
  logic                         loaded_q;
  logic [NUM_WORDS*W-1:0]       cfg_q;
  logic [NUM_WORDS-1:0][W-1:0]  otp_w;
  iv_kind_e                     kind;
  logic                         timeout, active, word_st, wr_en;
  logic                         div_w, inh_w;
  logic [SELW-1:0]              sel;
  logic [W-1:0]                 sel_word;

  assign active  = (state_q != '0);
  assign word_st = (state_q >= SW'(FIRST_W));
  assign sel     = SELW'(state_q - SW'(FIRST_W));
  assign wr_en   = active && word_st && store_i && arm_q && !start_i && !stop_i && !timeout;

  cfg_interval_timer #(
    .TIMEOUT_T(TIMEOUT_T), .WAIT_T(WAIT_T),
    .INC_LO(INC_LO), .INC_HI(INC_HI),
    .ZERO_LO(ZERO_LO), .ZERO_HI(ZERO_HI),
    .ONE_LO(ONE_LO), .ONE_HI(ONE_HI)
  ) u_timer (
    .clk_i, .rst_ni, .tick_i,
    .restart_i(start_i),
    .pulse_i  (mod_i && active),
    .kind_o   (kind),
    .timeout_o(timeout)
  );

  cfg_otp_bank #(.W(W), .N(NUM_WORDS)) u_otp (
    .clk_i, .blank_ni(otp_blank_ni),
    .wr_en_i(wr_en), .wr_sel_i(sel), .wr_data_i(sr_q),
    .words_o(otp_w)
  );

  cfg_meas_gen #(.NW(W - 1)) u_meas (
    .clk_i, .rst_ni, .tick_i,
    .step_cnt_i(cfg_q[W-1:1]),
    .div_o(div_w), .inh_o(inh_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      sr_q    <= '0;
      arm_q   <= 1'b0;
    end else if (start_i) begin
      state_q <= SW'(1);
      sr_q    <= '0;
      arm_q   <= 1'b0;
    end else if (active) begin
      if (stop_i || timeout || wr_en) begin
        state_q <= '0;
        arm_q   <= 1'b0;
      end else begin
        if (prestore_i && word_st) arm_q <= 1'b1;
        unique case (kind)
          IV_INC:  if (state_q != SW'(LAST_ST)) state_q <= state_q + 1'b1;
          IV_ZERO: sr_q <= {1'b0, sr_q[W-1:1]};
          IV_ONE:  sr_q <= {1'b1, sr_q[W-1:1]};
          default: ;
        endcase
      end
    end
  end

  // one copy of the cells per reset, held for the consumers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_q <= 1'b0;
      cfg_q    <= '0;
    end else if (!loaded_q) begin
      loaded_q <= 1'b1;
      cfg_q    <= otp_w;
    end
  end

  always_comb begin
    sel_word = '0;
    for (int k = 0; k < NUM_WORDS; k++)
      if (state_q == SW'(k + FIRST_W)) sel_word = otp_w[k];
  end

  always_comb begin
    if (state_q == SW'(1))      load_o = div_w;
    else if (state_q == SW'(2)) load_o = inh_w;
    else if (word_st)           load_o = |(sr_q & sel_word);
    else                        load_o = 1'b0;
  end

  assign state_o = state_q;
  assign cfg_o   = cfg_q;
endmodule

// File: rtl/cfg_pulse_decoder_chk.sv
module cfg_pulse_decoder_chk #(
  parameter int unsigned W         = 8,
  parameter int unsigned NUM_WORDS = 3,
  parameter int unsigned SW        = 3
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            otp_blank_ni,
  input logic                            start_i,
  input logic                            stop_i,
  input logic [SW-1:0]                   state_o,
  input logic                            load_o,
  input logic [NUM_WORDS*W-1:0]          cfg_o,
  input logic [NUM_WORDS-1:0][W-1:0]     otp_w
);
  logic [1:0] up_q;
  logic       bup_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) up_q <= '0;
    else if (up_q != 2'd2) up_q <= up_q + 1'b1;

  always_ff @(posedge clk_i or negedge otp_blank_ni)
    if (!otp_blank_ni) bup_q <= 1'b0;
    else bup_q <= 1'b1;

  AST_START_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> state_o == SW'(1)); // R2

  AST_STATE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= SW'(NUM_WORDS + 2)); // R4

  AST_STATE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q != 2'd0 && state_o != $past(state_o)) |->
      (state_o == '0 || state_o == SW'(1) || state_o == $past(state_o) + 1'b1)); // R4

  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> state_o == '0); // R9

  AST_IDLE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == '0 |-> !load_o); // R10

  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_q == 2'd2 |-> $stable(cfg_o)); // R13

  AST_SET_ONLY: assert property (@(posedge clk_i) disable iff (!otp_blank_ni)
    bup_q |-> (($past(otp_w) & ~otp_w) == '0)); // R7
endmodule

bind cfg_pulse_decoder cfg_pulse_decoder_chk #(
  .W(W), .NUM_WORDS(NUM_WORDS), .SW(SW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .otp_blank_ni(otp_blank_ni),
  .start_i(start_i), .stop_i(stop_i), .state_o(state_o),
  .load_o(load_o), .cfg_o(cfg_o), .otp_w(otp_w)
);

// File: tb/cfg_pulse_decoder_tb.sv
module cfg_pulse_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0, blank_n = 1'b0, tick = 1'b1;
  logic start = 1'b0, stop = 1'b0, modp = 1'b0, pre = 1'b0, store = 1'b0;
  logic [2:0]  state;
  logic        load;
  logic [23:0] cfg;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  cfg_pulse_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .otp_blank_ni(blank_n), .tick_i(tick),
    .start_i(start), .stop_i(stop), .mod_i(modp), .prestore_i(pre),
    .store_i(store), .state_o(state), .load_o(load), .cfg_o(cfg)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  // all drivers change at the falling edge, one cycle wide
  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask
  task automatic p_start(); start = 1; @(negedge clk); start = 0; endtask
  task automatic p_stop();  stop  = 1; @(negedge clk); stop  = 0; endtask
  task automatic p_pre();   pre   = 1; @(negedge clk); pre   = 0; endtask
  task automatic p_store(); store = 1; @(negedge clk); store = 0; endtask
  task automatic p_mod();   modp  = 1; @(negedge clk); modp  = 0; endtask
  task automatic gap(int k); idle(k); p_mod(); endtask

  task automatic open_session();
    p_start(); idle(660); p_mod();
  endtask

  task automatic send_word(logic [7:0] w, bit alt);
    for (int b = 0; b < 8; b++)
      if (w[b]) gap(alt ? 91 : 86);
      else      gap(alt ? 53 : 58);
  endtask

  task automatic t_reset();
    chk("R1 state", state, 0);
    chk("R1 load", load, 0);
    chk("R1 cfg", cfg, 0);
  endtask

  task automatic t_early();
    p_start();
    chk("R2 start state", state, 1);
    idle(100); p_mod(); gap(22);
    chk("R3 early pulses ignored", state, 1);
    idle(600); p_mod();
    chk("R3 reference only", state, 1);
    gap(22);
    chk("R4 step", state, 2);
    p_stop();
    chk("R9 stop", state, 0);
  endtask

  task automatic t_windows();
    open_session();
    gap(19); chk("R6 gap19", state, 1);
    gap(27); chk("R6 gap27", state, 1);
    gap(20); chk("R4 gap20", state, 2);
    gap(26); chk("R4 gap26", state, 3);
    gap(15); gap(10); chk("R6 restart", state, 3);
    gap(59); gap(20); chk("R6 gap59 then 20", state, 4);
    gap(23); chk("R4 to 5", state, 5);
    gap(21); chk("R4 saturate", state, 5);
    p_stop();
  endtask

  task automatic t_meas1();
    int hi = 0;
    open_session();
    for (int i = 0; i < 1024; i++) begin
      if (load) hi++;
      @(negedge clk);
    end
    chk("R11 high ticks", hi, 512);
    p_stop();
  endtask

  task automatic wr_word(int idx, logic [7:0] w, bit arm);
    open_session();
    for (int i = 0; i < idx + 2; i++) gap(22);
    send_word(w, 1'b0);
    if (arm) p_pre();
    p_store();
    chk(arm ? "R7 store ends" : "R8 bare store", state, arm ? 0 : 3 + idx);
    if (!arm) p_stop();
  endtask

  task automatic rd_word(int idx, logic [7:0] w, string req);
    open_session();
    for (int i = 0; i < idx + 2; i++) gap(22);
    chk("R2 cleared pointer", load, 0);
    gap(91);
    chk(req, load, w[7]);
    for (int j = 1; j < 8; j++) begin
      gap(53);
      chk(req, load, w[7-j]);
    end
    p_stop();
  endtask

  task automatic t_reload();
    chk("R13 held", cfg, 0);
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    idle(2);
    chk("R1 state after reset", state, 0);
    chk("R13 reload", cfg, 24'h3C008B);
  endtask

  task automatic t_meas2();
    int t = 0;
    open_session(); gap(22);
    while (!(load == 0)) @(negedge clk);
    while (load == 0) @(negedge clk);
    while (load == 1) begin t++; @(negedge clk); end
    chk("R12 high part", t, 512);
    while (load == 0) begin t++; @(negedge clk); end
    chk("R12 period", t, 1024 + 4 * 69);
    p_stop();
  endtask

  task automatic t_timeout();
    open_session();
    idle(65530);
    chk("R9 before timeout", state, 1);
    idle(10);
    chk("R9 timeout", state, 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1; blank_n = 1;
    idle(2);
    t_reset();
    t_early();
    t_windows();
    t_meas1();
    wr_word(0, 8'h0A, 1'b1);
    rd_word(0, 8'h0A, "R10 R5 word A");
    wr_word(1, 8'hFF, 1'b0);
    rd_word(1, 8'h00, "R8 word B untouched");
    wr_word(0, 8'h81, 1'b1);
    rd_word(0, 8'h8B, "R7 merged word A");
    wr_word(2, 8'h3C, 1'b1);
    t_reload();
    t_meas2();
    t_timeout();
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end
endmodule